// File: doc/BRIEF.md
# Dual Down-Counter Timer Register Block

This block is a byte-wide register file with sixteen registers. It holds two 16-bit down-counting timers, an interrupt flag register, an interrupt enable register and a set of plain storage bytes. A processor reaches the registers with single-cycle write and read strobes. Address bits 12 to 9 select the register, and the other address bits are ignored. Both timers move only in cycles where `tick_en` is high, so one tick source can set the timebase for the whole block.

Timer 1 runs without stopping. It counts down from its latch, passes 0 and 0xFFFF, and then reloads the latch, so one period is latch + 2 ticks. The state machine `dtimer_t1` has two states. In T1_RUN the counter decrements. The transition RUN→WRAP happens when a tick meets a zero count, and the counter becomes 0xFFFF. In T1_WRAP the next tick reloads the latch (WRAP→RUN). A load strobe forces the machine back into RUN.

Timer 2 fires once. The state machine `dtimer_t2` moves IDLE→ARMED when its high byte is written and the counter is loaded. It moves ARMED→IDLE on the tick that brings the counter to 0. The counter keeps counting down and wraps with no reload.

The flags and enables combine into one interrupt line. An external input sets the shift flag.

Top module: `dual_timer_regs`

## Requirements
- R1: The register index is `reg_addr[12:9]`, in this order: 0 port B, 1 port A, 2 direction B, 3 direction A, 4 T1 count low, 5 T1 count high, 6 T1 latch low, 7 T1 latch high, 8 T2 low, 9 T2 high, 10 shift, 11 aux control, 12 peripheral control, 13 flags, 14 enables, 15 port A (no handshake). The other address bits are ignored. Indices 0–3, 10, 11, 12 and 15 read back the value last written to them, and each is a separate register.
- R2: Each tick steps timer 1 through latch, …, 1, 0, 0xFFFF, and then back to the latch value, so one period is latch + 2 ticks. Its counter changes only on a tick or on a load.
- R3: The timer 1 flag (flags bit 6) is set on the tick that brings the counter to 0, and only while aux control bits 7:6 equal 01. For any other value the counter still runs but the flag is not set.
- R4: A write to T1 count low or T1 latch low changes only the latch low byte. A write to T1 count high sets the latch high byte, clears flag bit 6 and loads the counter from the latch. A write to T1 latch high sets the latch high byte and clears flag bit 6, but does not reload. The next wrap reloads from the updated latch.
- R5: These reads have side effects:
  - Reading T1 count low returns the count low byte and clears flag bit 6.
  - Reading T2 low returns the T2 count low byte and clears flag bit 5.
  - Reading shift clears flag bits 4:2.
  - Reads of the latch bytes and of T1 count high change nothing.
- R6: A write to T2 low stores a low byte. A write to T2 high loads the counter with {written byte, stored low byte}, clears flag bit 5 and arms timer 2. Timer 2 sets flag bit 5 once, on the tick that brings it to 0. It then keeps counting down from 0xFFFF with no reload and no further flag until it is reloaded.
- R7: An enables write with bit 7 = 1 ORs bits 6:0 into the enables. With bit 7 = 0 it clears every enable bit written as 1. An enables read returns bit 7 = 1.
- R8: A flags write clears each flag bit written as 1 and leaves the rest unchanged. A flags read returns bit 7 = 1 when any flag is both set and enabled.
- R9: `irq` is high when (flags AND enables) is nonzero in bits 2, 5 or 6. A one-cycle pulse on `sr_flag_in` sets flag bit 2. When a hardware set and a clear of the same flag fall in the same cycle, the set wins.
- R10: After reset:
  - both latches and the timer 1 counter are 0xFFFF;
  - direction B is 0xFF;
  - every other register is 0;
  - `irq` is low;
  - an enables read returns 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase enable; each high cycle is one timer tick |
| sr_flag_in | input | 1 | Pulse that sets the shift flag (bit 2) |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe; applies read side effects at the clock edge |
| reg_addr | input | 13 | Byte address; bits 12:9 select the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
`reg_rdata` is a combinational view of the selected register, so it is valid in the same cycle as the read strobe. The side effect of a read, and the effect of a write or a tick, appear in register state one edge later. `irq` is a combinational function of the registered flags, so it rises in the same cycle that the flag becomes visible. The bench drives strobes and ticks at the falling edge. It samples read data one step after driving the strobe, before the rising edge commits the side effect. It samples `irq` and later reads only after the edge that carries the expected update.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

    typedef enum logic [3:0] {
        RI_PORTB    = 4'd0,
        RI_PORTA    = 4'd1,
        RI_DIRB     = 4'd2,
        RI_DIRA     = 4'd3,
        RI_T1C_LO   = 4'd4,
        RI_T1C_HI   = 4'd5,
        RI_T1L_LO   = 4'd6,
        RI_T1L_HI   = 4'd7,
        RI_T2_LO    = 4'd8,
        RI_T2_HI    = 4'd9,
        RI_SHIFT    = 4'd10,
        RI_AUX      = 4'd11,
        RI_PERIPH   = 4'd12,
        RI_FLAGS    = 4'd13,
        RI_ENABLE   = 4'd14,
        RI_PORTA_NH = 4'd15
    } reg_idx_e;

    localparam int FLG_SHIFT = 2;
    localparam int FLG_SDATA = 3;
    localparam int FLG_SCLK  = 4;
    localparam int FLG_T2    = 5;
    localparam int FLG_T1    = 6;
    localparam int FLG_W     = 7;

    localparam logic [FLG_W-1:0] IRQ_SRC_MASK = 7'b110_0100;

    typedef enum logic {T1_RUN, T1_WRAP} t1_state_e;
    typedef enum logic {T2_IDLE, T2_ARMED} t2_state_e;

endpackage

// File: rtl/dtimer_t1.sv
module dtimer_t1
    import dtimer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            lat_lo_we,
    input  logic            lat_hi_we,
    input  logic            load_we,
    input  logic [DW-1:0]   wdata,
    input  logic            cont_mode,
    output logic [2*DW-1:0] cnt_q,
    output logic [2*DW-1:0] latch_q,
    output logic            fire
);
    localparam int CW = 2 * DW;

    t1_state_e      st_q, st_d;
    logic [CW-1:0]  cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= T1_RUN;
            cnt_q   <= '1;
            latch_q <= '1;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (lat_lo_we) latch_q[DW-1:0]  <= wdata;
            if (lat_hi_we) latch_q[CW-1:DW] <= wdata;
        end
    end

    // next state and outputs
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (load_we) begin
            cnt_d = {wdata, latch_q[DW-1:0]};
            st_d  = T1_RUN;
        end else if (tick) begin
            unique case (st_q)
                T1_RUN: begin
                    if (cnt_q == '0) begin
                        cnt_d = '1;
                        st_d  = T1_WRAP;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                        fire  = cont_mode && (cnt_q == CW'(1));
                    end
                end
                T1_WRAP: begin
                    cnt_d = latch_q;
                    st_d  = T1_RUN;
                    fire  = cont_mode && (latch_q == '0);
                end
            endcase
        end
    end

    AST_T1_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T1_WRAP && tick && !load_we && !lat_lo_we && !lat_hi_we) |=> (cnt_q == $past(latch_q))); // R2
    AST_T1_ZERO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T1_RUN && cnt_q == '0 && tick && !load_we) |=> (cnt_q == '1 && st_q == T1_WRAP)); // R2
    AST_T1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (cnt_q == {$past(wdata), $past(latch_q[DW-1:0])} && st_q == T1_RUN)); // R4

endmodule

// File: rtl/dtimer_t2.sv
module dtimer_t2
    import dtimer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            lat_lo_we,
    input  logic            load_we,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] cnt_q,
    output logic            fire
);
    localparam int CW = 2 * DW;

    t2_state_e      st_q, st_d;
    logic [CW-1:0]  cnt_d;
    logic [DW-1:0]  lat_lo_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= T2_IDLE;
            cnt_q    <= '0;
            lat_lo_q <= '1;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (lat_lo_we) lat_lo_q <= wdata;
        end
    end

    // next state and outputs
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (load_we) begin
            cnt_d = {wdata, lat_lo_q};
            st_d  = T2_ARMED;
        end else if (tick) begin
            cnt_d = cnt_q - 1'b1;
            unique case (st_q)
                T2_IDLE:  st_d = T2_IDLE;
                T2_ARMED: begin
                    if (cnt_q == CW'(1)) begin
                        fire = 1'b1;
                        st_d = T2_IDLE;
                    end
                end
            endcase
        end
    end

    AST_T2_FIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt_q == '0 && st_q == T2_IDLE)); // R6
    AST_T2_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T2_IDLE && !load_we) |=> (st_q == T2_IDLE)); // R6

endmodule

// File: rtl/dtimer_flags.sv
module dtimer_flags
    import dtimer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLG_W-1:0] set_mask,
    input  logic [FLG_W-1:0] clr_mask,
    input  logic             en_we,
    input  logic [DW-1:0]    wdata,
    output logic [FLG_W-1:0] flags_q,
    output logic [FLG_W-1:0] enables_q,
    output logic             any_pending,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q   <= '0;
            enables_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | set_mask;
            if (en_we) begin
                if (wdata[DW-1]) enables_q <= enables_q | wdata[FLG_W-1:0];
                else             enables_q <= enables_q & ~wdata[FLG_W-1:0];
            end
        end
    end

    always_comb begin
        any_pending = |(flags_q & enables_q);
        irq         = |(flags_q & enables_q & IRQ_SRC_MASK);
    end

    AST_IER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && wdata[DW-1]) |=> ((enables_q & $past(wdata[FLG_W-1:0])) == $past(wdata[FLG_W-1:0]))); // R7
    AST_IER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && !wdata[DW-1]) |=> ((enables_q & $past(wdata[FLG_W-1:0])) == '0)); // R7
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_mask[FLG_SHIFT] |=> flags_q[FLG_SHIFT]); // R9

endmodule

// File: rtl/dual_timer_regs.sv
module dual_timer_regs
    import dtimer_pkg::*;
#(
    parameter int          ADDR_W   = 13,
    parameter int          SEL_LSB  = 9,
    parameter int          DW       = 8,
    parameter logic [7:0]  DIRB_RST = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              sr_flag_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq
);
    localparam int SEL_W = 4;
    localparam int CW    = 2 * DW;
    localparam int TOP_W = ADDR_W - SEL_LSB - SEL_W;

    reg_idx_e sel;
    assign sel = reg_idx_e'(reg_addr[SEL_LSB +: SEL_W]);

    logic unused_addr_lo;
    assign unused_addr_lo = ^reg_addr[SEL_LSB-1:0];
    generate
        if (TOP_W > 0) begin : g_addr_hi
            logic unused_addr_hi;
            assign unused_addr_hi = ^reg_addr[ADDR_W-1:ADDR_W-TOP_W];
        end
    endgenerate

    // plain storage bytes
    logic [DW-1:0] portb_q, porta_q, dirb_q, dira_q;
    logic [DW-1:0] shift_q, aux_q, periph_q, porta_nh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            portb_q    <= '0;
            porta_q    <= '0;
            dirb_q     <= DIRB_RST;
            dira_q     <= '0;
            shift_q    <= '0;
            aux_q      <= '0;
            periph_q   <= '0;
            porta_nh_q <= '0;
        end else if (reg_wr) begin
            unique case (sel)
                RI_PORTB:    portb_q    <= reg_wdata;
                RI_PORTA:    porta_q    <= reg_wdata;
                RI_DIRB:     dirb_q     <= reg_wdata;
                RI_DIRA:     dira_q     <= reg_wdata;
                RI_SHIFT:    shift_q    <= reg_wdata;
                RI_AUX:      aux_q      <= reg_wdata;
                RI_PERIPH:   periph_q   <= reg_wdata;
                RI_PORTA_NH: porta_nh_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // decoded strobes
    logic wr_t1c_lo, wr_t1c_hi, wr_t1l_lo, wr_t1l_hi, wr_t2_lo, wr_t2_hi;
    logic wr_flags, wr_enable, rd_t1c_lo, rd_t2_lo, rd_shift;
    always_comb begin
        wr_t1c_lo = reg_wr && (sel == RI_T1C_LO);
        wr_t1c_hi = reg_wr && (sel == RI_T1C_HI);
        wr_t1l_lo = reg_wr && (sel == RI_T1L_LO);
        wr_t1l_hi = reg_wr && (sel == RI_T1L_HI);
        wr_t2_lo  = reg_wr && (sel == RI_T2_LO);
        wr_t2_hi  = reg_wr && (sel == RI_T2_HI);
        wr_flags  = reg_wr && (sel == RI_FLAGS);
        wr_enable = reg_wr && (sel == RI_ENABLE);
        rd_t1c_lo = reg_rd && (sel == RI_T1C_LO);
        rd_t2_lo  = reg_rd && (sel == RI_T2_LO);
        rd_shift  = reg_rd && (sel == RI_SHIFT);
    end

    logic [CW-1:0] t1_cnt, t1_latch, t2_cnt;
    logic          t1_fire, t2_fire, t1_cont;
    assign t1_cont = (aux_q[7:6] == 2'b01);

    dtimer_t1 #(.DW(DW)) u_t1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .lat_lo_we (wr_t1c_lo || wr_t1l_lo),
        .lat_hi_we (wr_t1c_hi || wr_t1l_hi),
        .load_we   (wr_t1c_hi),
        .wdata     (reg_wdata),
        .cont_mode (t1_cont),
        .cnt_q     (t1_cnt),
        .latch_q   (t1_latch),
        .fire      (t1_fire)
    );

    dtimer_t2 #(.DW(DW)) u_t2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .lat_lo_we (wr_t2_lo),
        .load_we   (wr_t2_hi),
        .wdata     (reg_wdata),
        .cnt_q     (t2_cnt),
        .fire      (t2_fire)
    );

    logic [FLG_W-1:0] set_mask, clr_mask, flags_q, enables_q;
    logic             any_pending;

    always_comb begin
        set_mask            = '0;
        set_mask[FLG_T1]    = t1_fire;
        set_mask[FLG_T2]    = t2_fire;
        set_mask[FLG_SHIFT] = sr_flag_in;

        clr_mask = wr_flags ? reg_wdata[FLG_W-1:0] : '0;
        if (wr_t1c_hi || wr_t1l_hi || rd_t1c_lo) clr_mask[FLG_T1] = 1'b1;
        if (wr_t2_hi || rd_t2_lo)                clr_mask[FLG_T2] = 1'b1;
        if (rd_shift) begin
            clr_mask[FLG_SHIFT] = 1'b1;
            clr_mask[FLG_SDATA] = 1'b1;
            clr_mask[FLG_SCLK]  = 1'b1;
        end
    end

    dtimer_flags #(.DW(DW)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_mask    (set_mask),
        .clr_mask    (clr_mask),
        .en_we       (wr_enable),
        .wdata       (reg_wdata),
        .flags_q     (flags_q),
        .enables_q   (enables_q),
        .any_pending (any_pending),
        .irq         (irq)
    );

    // read mux
    always_comb begin
        unique case (sel)
            RI_PORTB:    reg_rdata = portb_q;
            RI_PORTA:    reg_rdata = porta_q;
            RI_DIRB:     reg_rdata = dirb_q;
            RI_DIRA:     reg_rdata = dira_q;
            RI_T1C_LO:   reg_rdata = t1_cnt[DW-1:0];
            RI_T1C_HI:   reg_rdata = t1_cnt[CW-1:DW];
            RI_T1L_LO:   reg_rdata = t1_latch[DW-1:0];
            RI_T1L_HI:   reg_rdata = t1_latch[CW-1:DW];
            RI_T2_LO:    reg_rdata = t2_cnt[DW-1:0];
            RI_T2_HI:    reg_rdata = t2_cnt[CW-1:DW];
            RI_SHIFT:    reg_rdata = shift_q;
            RI_AUX:      reg_rdata = aux_q;
            RI_PERIPH:   reg_rdata = periph_q;
            RI_FLAGS:    reg_rdata = {any_pending, flags_q};
            RI_ENABLE:   reg_rdata = {1'b1, enables_q};
            RI_PORTA_NH: reg_rdata = porta_nh_q;
        endcase
    end

    AST_T1_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_q[7:6] != 2'b01 && !flags_q[FLG_T1]) |=> !flags_q[FLG_T1]); // R3
    AST_FLAG_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flags && reg_wdata[FLG_T2] && !t2_fire) |=> !flags_q[FLG_T2]); // R8
    AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> any_pending); // R9

endmodule

// File: tb/dual_timer_regs_bench.sv
module dual_timer_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        sr_flag_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [12:0] reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_timer_regs u_dual_timer_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .sr_flag_in (sr_flag_in),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

    // {wr, idx, data, expected read, requirement number}
    localparam int NV = 29;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 4'h2, 8'h00, 8'hFF, 4'd10},   // R10 dir B
        {1'b0, 4'h6, 8'h00, 8'hFF, 4'd10},   // R10 T1 latch low
        {1'b0, 4'h7, 8'h00, 8'hFF, 4'd10},   // R10 T1 latch high
        {1'b0, 4'h4, 8'h00, 8'hFF, 4'd10},   // R10 T1 count low
        {1'b0, 4'h5, 8'h00, 8'hFF, 4'd10},   // R10 T1 count high
        {1'b0, 4'h0, 8'h00, 8'h00, 4'd10},   // R10 port B
        {1'b0, 4'hE, 8'h00, 8'h80, 4'd10},   // R10 enables
        {1'b1, 4'h1, 8'h5A, 8'h00, 4'd1},
        {1'b0, 4'h1, 8'h00, 8'h5A, 4'd1},    // R1 port A
        {1'b1, 4'hF, 8'h3C, 8'h00, 4'd1},
        {1'b0, 4'hF, 8'h00, 8'h3C, 4'd1},    // R1 no-handshake port
        {1'b0, 4'h1, 8'h00, 8'h5A, 4'd1},    // R1 separate from index 15
        {1'b1, 4'hC, 8'hA5, 8'h00, 4'd1},
        {1'b0, 4'hC, 8'h00, 8'hA5, 4'd1},    // R1 peripheral control
        {1'b1, 4'h3, 8'h0F, 8'h00, 4'd1},
        {1'b0, 4'h3, 8'h00, 8'h0F, 4'd1},    // R1 dir A
        {1'b1, 4'h6, 8'h34, 8'h00, 4'd4},
        {1'b0, 4'h6, 8'h00, 8'h34, 4'd4},    // R4 latch low stored
        {1'b0, 4'h4, 8'h00, 8'hFF, 4'd4},    // R4 counter untouched
        {1'b1, 4'h4, 8'h12, 8'h00, 4'd4},
        {1'b0, 4'h6, 8'h00, 8'h12, 4'd4},    // R4 count-low write goes to latch
        {1'b1, 4'h5, 8'h56, 8'h00, 4'd4},
        {1'b0, 4'h5, 8'h00, 8'h56, 4'd4},    // R4 reload high
        {1'b0, 4'h4, 8'h00, 8'h12, 4'd4},    // R4 reload low
        {1'b0, 4'h7, 8'h00, 8'h56, 4'd5},    // R5 latch read no effect
        {1'b1, 4'hE, 8'h85, 8'h00, 4'd7},
        {1'b0, 4'hE, 8'h00, 8'h85, 4'd7},    // R7 set
        {1'b1, 4'hE, 8'h01, 8'h00, 4'd7},
        {1'b0, 4'hE, 8'h00, 8'h84, 4'd7}     // R7 clear
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {idx, 9'h0AB}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = {idx, 9'h155};
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [3:0] idx, input logic [7:0] exp);
        logic [7:0] v;
        rd(idx, v);
        chk(req, v, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 irq", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] v;
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
            if (VEC[i][24]) wr(VEC[i][23:20], VEC[i][19:12]);
            else begin
                rd(VEC[i][23:20], v);
                chk(tag, v, VEC[i][11:4]);
            end
        end
        rdchk("R8 flags idle", 4'hD, 8'h00);

        // R2 timer 1 period latch+2 in continuous mode
        wr(4'hB, 8'h40);
        wr(4'h6, 8'h03);
        wr(4'h5, 8'h00);
        wr(4'hE, 8'h7F);
        wr(4'hE, 8'hC0);
        ticks(3);
        chk("R9 irq on T1", {7'd0, irq}, 8'h01);
        rdchk("R2 flag at zero", 4'hD, 8'hC0);
        wr(4'hD, 8'h40);
        rdchk("R8 flag cleared by write", 4'hD, 8'h00);
        chk("R9 irq low", {7'd0, irq}, 8'h00);
        ticks(1);
        rdchk("R2 wraps to FFFF", 4'h5, 8'hFF);
        ticks(1);
        rdchk("R2 reload high", 4'h5, 8'h00);
        rdchk("R2 reload low", 4'h4, 8'h03);
        ticks(2);
        rdchk("R2 no early flag", 4'hD, 8'h00);
        ticks(1);
        rdchk("R2 flag after latch+2", 4'hD, 8'hC0);
        rdchk("R5 count low read", 4'h4, 8'h00);
        rdchk("R5 read cleared T1 flag", 4'hD, 8'h00);

        // R4 latch-high write: clears flag, no reload
        ticks(5);
        rdchk("R4 flag set again", 4'hD, 8'hC0);
        wr(4'h7, 8'h07);
        rdchk("R4 latch-high clears flag", 4'hD, 8'h00);
        rdchk("R4 no reload", 4'h5, 8'h00);
        rdchk("R4 latch high stored", 4'h7, 8'h07);
        ticks(2);
        rdchk("R4 wrap uses new latch", 4'h5, 8'h07);

        // R3 other aux modes do not flag
        wr(4'hB, 8'h00);
        wr(4'h6, 8'h02);
        wr(4'h5, 8'h00);
        ticks(2);
        rdchk("R3 aux 00 no flag", 4'hD, 8'h00);
        rdchk("R3 counter still runs", 4'h4, 8'h00);
        wr(4'hB, 8'hC0);
        wr(4'h5, 8'h00);
        ticks(2);
        rdchk("R3 aux 11 no flag", 4'hD, 8'h00);
        wr(4'hB, 8'h00);

        // R6 timer 2 one-shot
        wr(4'hE, 8'h7F);
        wr(4'hE, 8'hA0);
        wr(4'h8, 8'h02);
        wr(4'h9, 8'h00);
        ticks(1);
        rdchk("R6 T2 counting", 4'h8, 8'h01);
        rdchk("R6 no flag yet", 4'hD, 8'h00);
        ticks(1);
        chk("R9 irq on T2", {7'd0, irq}, 8'h01);
        rdchk("R6 flag at zero", 4'hD, 8'hA0);
        rdchk("R5 T2 low read", 4'h8, 8'h00);
        rdchk("R5 T2 read cleared flag", 4'hD, 8'h00);
        ticks(1);
        rdchk("R6 no reload high", 4'h9, 8'hFF);
        ticks(65535);
        rdchk("R6 back at zero high", 4'h9, 8'h00);
        rdchk("R6 no second flag", 4'hD, 8'h00);
        wr(4'h9, 8'h00);
        ticks(2);
        rdchk("R6 rearmed flag", 4'hD, 8'hA0);
        rdchk("R5 clear T2", 4'h8, 8'h00);

        // R9 shift flag input and masking
        wr(4'hE, 8'h7F);
        @(negedge clk);
        sr_flag_in = 1'b1;
        @(negedge clk);
        sr_flag_in = 1'b0;
        chk("R9 disabled source no irq", {7'd0, irq}, 8'h00);
        rdchk("R9 shift flag set", 4'hD, 8'h04);
        wr(4'hE, 8'h84);
        chk("R9 enabled source irq", {7'd0, irq}, 8'h01);
        rdchk("R8 summary bit", 4'hD, 8'h84);
        wr(4'hD, 8'h00);
        rdchk("R8 zero write keeps flag", 4'hD, 8'h84);
        rdchk("R5 shift read value", 4'hA, 8'h00);
        rdchk("R5 shift read clears", 4'hD, 8'h00);
        chk("R9 irq dropped", {7'd0, irq}, 8'h00);

        finish_run();
    end

endmodule